// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the sequencing core of an on-chip debug unit. It watches three single-cycle match pulses from comparators elsewhere in the chip, named M0, M1 and M2. It walks through three working states, State1, State2 and State3, and one terminal Final state. Each working state has its own 4-bit control code, which decides which match pulses move the sequencer and where they send it. Reaching the Final state raises a single-cycle trigger that can serve as a breakpoint request.

Because the transitions come from run-time codes, one block can detect ordering violations that a fixed detector cannot. Three examples:
- a match that fails to follow one of two other matches before they repeat;
- M0 arriving after one or two M2 events with no M1 reset between them;
- the third consecutive M0 with no M1 reset, found by setting two comparators to the same match.

Software loads the codes while the sequencer is disarmed. It then raises the arm input. The sequencer starts in State1 and runs until it reaches Final. It stays in Final until it is disarmed and armed again.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset, `state_o` is 0 (State1), `trig_o` is low, and all three control codes are 4'b0000.
- R2: `state_o` encodes State1=0, State2=1, State3=2, Final=3. `trig_o` is high for exactly one cycle: the cycle in which `state_o` first shows 3. That is one clock after the match that caused the move.
- R3: The low bits `code[1:0]` pick the forward event: 00 none, 01 M0, 10 M1, 11 M2. With `code[3:2]`=00, the forward event moves to the next state. The state after State3 is Final.
- R4: With `code[3:2]`=01, the forward event acts as in R3. In addition, M1 returns to State1, unless M1 is itself the forward event.
- R5: With `code[3:2]`=10, the forward event goes straight to Final. M1 returns to State1, unless M1 is itself the forward event.
- R6: With `code[3:2]`=11, M0 OR M1 is the forward event. With `code[1]`=0 it goes to the next state; with `code[1]`=1 it goes to Final. With `code[0]`=1, M2 returns to State1.
- R7: When several match pulses arrive in one cycle, the transition of the highest-priority pulse that has one defined wins. The priority order is M0, then M1, then M2. A coincident pulse with no transition defined is ignored.
- R8: While the arm input is high, Final is held. While arm is low, the next state is State1, `trig_o` stays low, and no match moves the sequencer.
- R9: A write with `cfg_sel_i` 0, 1 or 2 loads the code of State1, State2 or State3. Writes are taken only while arm is low. Writes made while armed are ignored, and so are writes with `cfg_sel_i`=3.
- R10: A cycle with no match pulse, or only pulses with no transition defined in the current state, leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm level; low holds the sequencer idle in State1 |
| m0_i | input | 1 | Match pulse M0 (highest priority) |
| m1_i | input | 1 | Match pulse M1 |
| m2_i | input | 1 | Match pulse M2 (lowest priority) |
| cfg_we_i | input | 1 | Control code write strobe |
| cfg_sel_i | input | 2 | Target working state of the write (0..2) |
| cfg_code_i | input | 4 | Control code to write |
| state_o | output | 2 | Current state, encoded as in R2 |
| trig_o | output | 1 | One-cycle trigger on entry into Final |

## Verification
The checker asserts the following on every cycle:
- the trigger is a single-cycle pulse that coincides with the first cycle of Final;
- Final is held while armed;
- disarming returns the sequencer to State1;
- a cycle without matches never moves the state;
- the code bank stays unchanged across armed writes and across writes to the unused select value.

Which destination a given code picks, and the M0-over-M1-over-M2 resolution of coincident pulses, are shown only by the bench. The bench covers:
- the two-M2 scenario;
- the M2-then-M1 ordering scenario;
- the M0-or-M1 watchdog scenario;
- the third-coincident-M0 scenario;
- a long random run compared cycle by cycle against a behavioural model.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

    // Number of working states, events and code width
    localparam int NUM_ST  = 3;
    localparam int NUM_EV  = 3;
    localparam int CODE_W  = 4;
    localparam int SEL_W   = $clog2(NUM_ST + 1);
    localparam int STATE_W = 2;

    // Action field values (code[3:2])
    localparam logic [1:0] ACT_FWD      = 2'b00;
    localparam logic [1:0] ACT_FWD_RET  = 2'b01;
    localparam logic [1:0] ACT_FIN_RET  = 2'b10;
    localparam logic [1:0] ACT_EITHER   = 2'b11;

    typedef enum logic [STATE_W-1:0] {
        ST_S1    = 2'd0,
        ST_S2    = 2'd1,
        ST_S3    = 2'd2,
        ST_FINAL = 2'd3
    } seq_state_e;

    // One candidate transition for one event
    typedef struct packed {
        logic       hit;
        seq_state_e dst;
    } xfer_t;

    // Candidate transitions for every event, index = event number
    typedef xfer_t [NUM_EV-1:0] rule_t;

    typedef logic [NUM_ST-1:0][CODE_W-1:0] code_bank_t;

    function automatic seq_state_e next_state(input seq_state_e cur);
        logic [STATE_W-1:0] v;
        v = cur;
        return seq_state_e'(v + 2'd1);
    endfunction

    // Turn one 4-bit code into the per-event transitions for a state
    function automatic rule_t decode_code(input logic [CODE_W-1:0] code,
                                          input seq_state_e cur);
        rule_t      r;
        seq_state_e fwd;
        logic [1:0] act;
        logic [1:0] evsel;
        r     = '0;
        act   = code[3:2];
        evsel = code[1:0];
        if (act == ACT_EITHER) begin
            fwd  = code[1] ? ST_FINAL : next_state(cur);
            r[0] = '{hit: 1'b1, dst: fwd};
            r[1] = '{hit: 1'b1, dst: fwd};
            if (code[0]) begin
                r[2] = '{hit: 1'b1, dst: ST_S1};
            end
        end else begin
            fwd = (act == ACT_FIN_RET) ? ST_FINAL : next_state(cur);
            if (act != ACT_FWD) begin
                r[1] = '{hit: 1'b1, dst: ST_S1};
            end
            if (evsel != 2'b00) begin
                r[evsel - 2'd1] = '{hit: 1'b1, dst: fwd};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/dbg_seq_cfg.sv
module dbg_seq_cfg
    import dbg_seq_pkg::*;
#(
    parameter int N_ST   = NUM_ST,
    parameter int C_W    = CODE_W,
    parameter int S_W    = SEL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      arm_i,
    input  logic                      we_i,
    input  logic [S_W-1:0]            sel_i,
    input  logic [C_W-1:0]            data_i,
    output logic [N_ST-1:0][C_W-1:0]  code_o
);

    localparam int LAST_IDX = N_ST - 1;

    logic [N_ST-1:0][C_W-1:0] code_q;
    logic                     wr_ok;

    // Writes are taken only while disarmed
    assign wr_ok = we_i && !arm_i;

    for (genvar g = 0; g <= LAST_IDX; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                code_q[g] <= '0;
            end else if (wr_ok && (sel_i == S_W'(g))) begin
                code_q[g] <= data_i;
            end
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/dbg_seq_decode.sv
module dbg_seq_decode
    import dbg_seq_pkg::*;
(
    input  seq_state_e cur_i,
    input  code_bank_t code_i,
    output rule_t      rule_o
);

    rule_t rules_all [NUM_ST];

    // Decode every working state in parallel, then pick the current one
    for (genvar g = 0; g < NUM_ST; g++) begin : g_dec
        assign rules_all[g] = decode_code(code_i[g], seq_state_e'(g));
    end

    always_comb begin
        rule_o = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (cur_i == seq_state_e'(i)) begin
                rule_o = rules_all[i];
            end
        end
    end

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
    import dbg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic [NUM_EV-1:0] match_i,
    input  rule_t             rule_i,
    output seq_state_e        state_o,
    output logic              trig_o
);

    seq_state_e state_q;
    seq_state_e state_nx;
    logic       trig_q;

    // Fixed priority: lower event index wins, so scan from high to low
    always_comb begin
        state_nx = state_q;
        if (state_q != ST_FINAL) begin
            for (int i = NUM_EV - 1; i >= 0; i--) begin
                if (match_i[i] && rule_i[i].hit) begin
                    state_nx = rule_i[i].dst;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_S1;
            trig_q  <= 1'b0;
        end else if (!arm_i) begin
            state_q <= ST_S1;
            trig_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            trig_q  <= (state_nx == ST_FINAL) && (state_q != ST_FINAL);
        end
    end

    assign state_o = state_q;
    assign trig_o  = trig_q;

endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
    import dbg_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             m0_i,
    input  logic             m1_i,
    input  logic             m2_i,
    input  logic             cfg_we_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic [CODE_W-1:0] cfg_code_i,
    output logic [STATE_W-1:0] state_o,
    output logic             trig_o
);

    code_bank_t        code_q;
    rule_t             rule_cur;
    seq_state_e        state_cur;
    logic [NUM_EV-1:0] match_vec;

    assign match_vec = {m2_i, m1_i, m0_i};

    dbg_seq_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .arm_i  (arm_i),
        .we_i   (cfg_we_i),
        .sel_i  (cfg_sel_i),
        .data_i (cfg_code_i),
        .code_o (code_q)
    );

    dbg_seq_decode u_dec (
        .cur_i  (state_cur),
        .code_i (code_q),
        .rule_o (rule_cur)
    );

    dbg_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .arm_i   (arm_i),
        .match_i (match_vec),
        .rule_i  (rule_cur),
        .state_o (state_cur),
        .trig_o  (trig_o)
    );

    assign state_o = state_cur;

endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk
    import dbg_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              arm_i,
    input logic              m0_i,
    input logic              m1_i,
    input logic              m2_i,
    input logic              cfg_we_i,
    input logic [SEL_W-1:0]  cfg_sel_i,
    input logic [STATE_W-1:0] state_o,
    input logic              trig_o,
    input code_bank_t        code_q
);

    localparam logic [STATE_W-1:0] ENC_S1  = 2'd0;
    localparam logic [STATE_W-1:0] ENC_FIN = 2'd3;

    // R2: trigger lasts one cycle
    p_trig_single_r2: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);

    // R2: trigger only while in Final
    p_trig_in_final_r2: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> (state_o == ENC_FIN));

    // R2: first cycle of Final carries the trigger
    p_trig_on_entry_r2: assert property (@(posedge clk) disable iff (rst)
        ((state_o == ENC_FIN) && ($past(state_o) != ENC_FIN)) |-> trig_o);

    // R8: Final held while armed
    p_final_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (arm_i && (state_o == ENC_FIN)) |=> (state_o == ENC_FIN));

    // R8: disarm returns to State1 without trigger
    p_disarm_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !arm_i |=> ((state_o == ENC_S1) && !trig_o));

    // R10: no match, no move
    p_quiet_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (arm_i && !m0_i && !m1_i && !m2_i) |=> $stable(state_o));

    // R9: armed writes are ignored
    p_armed_wr_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> $stable(code_q));

    // R9: unused select value is ignored
    p_bad_sel_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we_i && (cfg_sel_i == SEL_W'(NUM_ST))) |=> $stable(code_q));

endmodule

bind dbg_seq_top dbg_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .arm_i     (arm_i),
    .m0_i      (m0_i),
    .m1_i      (m1_i),
    .m2_i      (m2_i),
    .cfg_we_i  (cfg_we_i),
    .cfg_sel_i (cfg_sel_i),
    .state_o   (state_o),
    .trig_o    (trig_o),
    .code_q    (code_q)
);

// File: tb/dbg_seq_top_bench.sv
module dbg_seq_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       arm_i = 1'b0;
    logic       m0_i = 1'b0, m1_i = 1'b0, m2_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [1:0] cfg_sel_i = 2'd0;
    logic [3:0] cfg_code_i = 4'd0;
    logic [1:0] state_o;
    logic       trig_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    // Reference model state
    int ref_st = 0;
    int ref_trig = 0;
    int ref_code [3] = '{0, 0, 0};
    int trig_seen = 0;

    always #4 clk = ~clk;

    dbg_seq_top u_dbg_seq_top (
        .clk(clk), .rst(rst), .arm_i(arm_i),
        .m0_i(m0_i), .m1_i(m1_i), .m2_i(m2_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_code_i(cfg_code_i),
        .state_o(state_o), .trig_o(trig_o)
    );

    // Destination of event ev in state cur under code, -1 if none (R3..R6)
    function automatic int ref_dest(int code, int cur, int ev);
        int act = code / 4;
        int sel = code % 4;
        int nx  = cur + 1;
        if (act == 3) begin
            if (ev < 2) return ((code / 2) % 2 == 1) ? 3 : nx;
            if (code % 2 == 1) return 0;
            return -1;
        end
        if (sel != 0 && ev == sel - 1) return (act == 2) ? 3 : nx;
        if (act != 0 && ev == 1) return 0;
        return -1;
    endfunction

    task automatic check(input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, got, exp);
        end
    endtask

    // One clock: update model at the edge, compare away from it
    task automatic cyc();
        int evs [3];
        int nst;
        @(posedge clk);
        evs[0] = m0_i; evs[1] = m1_i; evs[2] = m2_i;
        if (rst) begin
            ref_st = 0; ref_trig = 0;
            foreach (ref_code[k]) ref_code[k] = 0;
        end else begin
            ref_trig = 0;
            if (!arm_i) begin
                ref_st = 0;
            end else if (ref_st != 3) begin
                nst = -1;
                for (int e = 0; e < 3; e++) begin
                    if (nst < 0 && evs[e] == 1) nst = ref_dest(ref_code[ref_st], ref_st, e);
                end
                if (nst >= 0) begin
                    ref_trig = (nst == 3) ? 1 : 0;
                    ref_st = nst;
                end
            end
            if (cfg_we_i && !arm_i && cfg_sel_i < 3) ref_code[cfg_sel_i] = cfg_code_i;
        end
        @(negedge clk);
        check(state_o, ref_st, "state_o");
        check(trig_o, ref_trig, "trig_o");
        if (trig_o) trig_seen++;
    endtask

    task automatic pulse(input bit a, input bit b, input bit c);
        m0_i = a; m1_i = b; m2_i = c;
        cyc();
        m0_i = 0; m1_i = 0; m2_i = 0;
    endtask

    task automatic write_code(input int sel, input int code);
        cfg_we_i = 1; cfg_sel_i = 2'(sel); cfg_code_i = 4'(code);
        cyc();
        cfg_we_i = 0;
    endtask

    task automatic setup(input int c1, input int c2, input int c3);
        arm_i = 0;
        cyc();
        write_code(0, c1); write_code(1, c2); write_code(2, c3);
        arm_i = 1;
        cyc();
        trig_seen = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        repeat (3) cyc();
        rst = 0;
        check(state_o, 0, "reset state");
        check(trig_o, 0, "reset trig");
        arm_i = 1;
        pulse(1, 1, 1);
        check(state_o, 0, "all-zero codes hold State1");

        // R4 R3: two-M2 mode, M1 reset after one M2
        cur_req = "R4";
        setup(4'b0011, 4'b0111, 4'b0101);
        pulse(0, 0, 1); check(state_o, 1, "first M2 -> State2");
        pulse(0, 1, 0); check(state_o, 0, "M1 returns to State1");
        pulse(0, 0, 1); pulse(0, 0, 1); check(state_o, 2, "second M2 -> State3");
        cur_req = "R3";
        pulse(1, 0, 0); check(state_o, 3, "M0 from State3 -> Final");
        cur_req = "R2";
        check(trig_o, 1, "trigger on entry");
        cyc(); check(trig_o, 0, "trigger one cycle");
        cur_req = "R8";
        pulse(1, 1, 1); check(state_o, 3, "Final held while armed");
        check(trig_seen, 1, "single trigger");
        arm_i = 0; cyc(); check(state_o, 0, "disarm -> State1");
        pulse(0, 0, 1); check(state_o, 0, "disarmed ignores match");

        // R5: ordering mode, M0 before M1 after M2 triggers
        cur_req = "R5";
        setup(4'b0011, 4'b1001, 4'b0000);
        pulse(0, 0, 1); pulse(0, 1, 0); check(state_o, 0, "M1 after M2 returns");
        pulse(0, 0, 1); pulse(1, 0, 0); check(state_o, 3, "M0 before M1 -> Final");
        check(trig_o, 1, "ordering trigger");

        // R6: M0 or M1 watchdog on M2
        cur_req = "R6";
        setup(4'b1100, 4'b1111, 4'b0000);
        pulse(0, 1, 0); check(state_o, 1, "M1 moves via OR");
        pulse(0, 0, 1); check(state_o, 0, "M2 returns to State1");
        pulse(1, 0, 0); pulse(0, 1, 0); check(state_o, 3, "repeat without M2 -> Final");

        // R7: coincident M0+M2 -> third occurrence triggers
        cur_req = "R7";
        setup(4'b0011, 4'b0111, 4'b0101);
        pulse(1, 0, 1); check(state_o, 1, "coincident #1 uses M2");
        pulse(1, 0, 1); check(state_o, 2, "coincident #2 uses M2");
        pulse(1, 0, 1); check(state_o, 3, "coincident #3 M0 wins");
        setup(4'b0000, 4'b0111, 4'b0101);
        cur_req = "R10";
        pulse(1, 1, 1); check(state_o, 0, "undefined events leave state");
        cur_req = "R7";
        setup(4'b0011, 4'b0111, 4'b0101);
        pulse(0, 0, 1); pulse(0, 1, 1); check(state_o, 0, "M1 beats M2");

        // R9: armed write and bad select ignored
        cur_req = "R9";
        setup(4'b0011, 4'b0000, 4'b0000);
        write_code(0, 4'b0000);
        pulse(0, 0, 1); check(state_o, 1, "armed write ignored");
        arm_i = 0; cyc();
        write_code(3, 4'b0000);
        write_code(0, 4'b0001);
        arm_i = 1; cyc();
        pulse(0, 0, 1); check(state_o, 0, "new code ignores M2");
        pulse(1, 0, 0); check(state_o, 1, "disarmed write taken");

        // Random run against the model
        cur_req = "R7";
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 59) == 0) begin
                arm_i = 0; cyc();
                write_code($urandom_range(0, 3), $urandom_range(0, 15));
                write_code($urandom_range(0, 3), $urandom_range(0, 15));
                arm_i = 1;
            end
            cfg_we_i = ($urandom_range(0, 9) == 0);
            cfg_sel_i = 2'($urandom_range(0, 3));
            cfg_code_i = 4'($urandom_range(0, 15));
            pulse($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
                  $urandom_range(0, 2) == 0);
            cfg_we_i = 0;
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule